// File: doc/BRIEF.md
# Divider Configuration Loader for a Clock Synthesizer

This block holds the settings a frequency synthesizer needs: a 9-bit feedback divider value, a 3-bit output divider code and a 2-bit test-select field. Two ports can load them. The parallel port is a set of level inputs gated by an active-low load strobe. The three-wire serial port is made of a shift clock, a data line and a load strobe. All strobes and the serial clock are treated as level inputs that are synchronous to the system clock `clk`. Edges are detected by comparing each input with its value on the previous clock, so every effect appears on the registered outputs one `clk` cycle later.

While the parallel strobe is low, the divider outputs follow the parallel inputs. Its rising edge freezes them. While the parallel strobe is high, the serial port shifts data into a 14-bit register. A rising edge on the serial load strobe copies that register into the holding registers. While the strobe stays high, each serial clock edge copies again, and its falling edge leaves the values frozen. A serial load always wins over a value captured from the parallel port.

A test output picks one of four sources according to the test-select field: constant low, the shift register's oldest bit, the feedback divider output or the synthesized clock. It is forced low while the block is in parallel mode. The divider reset input `mr` never touches the stored settings. It only holds the two divider-driven test sources low.

Top module: `cfg_loader`

## Requirements
- R1: While `pload_n` is 0, `m_val` and `n_code` equal the values `par_m` and `par_n` had at the previous `clk` edge.
- R2: In the cycle where `pload_n` rises to 1, `par_m`/`par_n` are captured, provided `ser_load` is 0. They hold while `pload_n` stays 1 and no serial load occurs.
- R3: While `pload_n` is 1, each rising edge of `ser_clk` shifts `ser_data` into the LSB of a 14-bit register, with the MSB sent first. A rising edge of `ser_load` then loads the outputs from it: bits [8:0] go to `m_val`, bits [11:9] to `n_code`, and bits [13:12] to the test-select field.
- R4: After `ser_load` falls, further serial shifts leave `m_val` and `n_code` unchanged.
- R5: While `ser_load` is held at 1 (with `pload_n` at 1), every rising edge of `ser_clk` updates the outputs from the freshly shifted register.
- R6: Test-select 00 drives `test_out` low. 01 drives the shift register's MSB, which is the bit shifted in longest ago. 10 drives `fb_div_in`. 11 drives `out_clk_in`.
- R7: `test_out` is low from reset until the first serial load. It is also low in the cycle after any cycle with `pload_n` at 0.
- R8: `mr` leaves `m_val`, `n_code` and the test-select field unchanged. While `mr` is 1, the sources selected by 10 and 11 read as 0.
- R9: While `pload_n` is 0, `ser_clk` and `ser_load` neither shift the register nor load the outputs.
- R10: While `rst_n` is 0, `m_val` is 250, `n_code` is 0, the test-select field is 00 and the shift register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| mr | input | 1 | Divider reset; masks divider-driven test sources |
| pload_n | input | 1 | Active-low parallel load strobe |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 3 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| fb_div_in | input | 1 | Feedback divider output, test source |
| out_clk_in | input | 1 | Synthesized output clock, test source |
| m_val | output | 9 | Feedback divider setting |
| n_code | output | 3 | Output divider code |
| test_out | output | 1 | Selected test signal |

## Verification
The hardest state to reach from the ports is a serial load that arrives while the serial load strobe is held high. In that state the outputs must move with every shift and not only on the strobe edge. The stimulus raises `ser_load`, leaves it high, and then clocks further bits. After each shift it checks the outputs against a shift value that the bench computes itself. A second hard case is a register that must not move during parallel mode. The bench shows this by pulsing serial traffic while `pload_n` is low. It then loads that register later and finds the older serial word still in it.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int M_W   = 9,
  parameter int N_W   = 3,
  parameter int M_RST = 250,
  parameter int N_RST = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           pload_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           fb_div_in,
  input  logic           out_clk_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic           test_out
);
  localparam int T_W  = 2;
  localparam int SR_W = T_W + N_W + M_W;

  logic            pload_q, sclk_q, sload_q, ser_mode;
  logic [SR_W-1:0] sr, sr_nx;
  logic [T_W-1:0]  t_sel;

  wire sclk_rise  = ser_clk & ~sclk_q;
  wire sload_rise = ser_load & ~sload_q;
  wire shift_en   = pload_n & sclk_rise;
  wire ser_take   = pload_n & ser_load & (sload_rise | sclk_rise);
  wire par_take   = ~pload_n | ~pload_q;

  assign sr_nx = shift_en ? {sr[SR_W-2:0], ser_data} : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pload_q  <= 1'b1;
      sclk_q   <= 1'b0;
      sload_q  <= 1'b0;
      sr       <= '0;
      m_val    <= M_W'(M_RST);
      n_code   <= N_W'(N_RST);
      t_sel    <= '0;
      ser_mode <= 1'b0;
    end else begin
      pload_q <= pload_n;
      sclk_q  <= ser_clk;
      sload_q <= ser_load;
      sr      <= sr_nx;
      if (ser_take) begin
        {t_sel, n_code, m_val} <= sr_nx;
        ser_mode               <= 1'b1;
      end else if (par_take) begin
        m_val    <= par_m;
        n_code   <= par_n;
        ser_mode <= 1'b0;
      end
    end
  end

  logic mux_out;
  always_comb begin
    case (t_sel)
      2'b00:   mux_out = 1'b0;
      2'b01:   mux_out = sr[SR_W-1];
      2'b10:   mux_out = fb_div_in & ~mr;
      default: mux_out = out_clk_in & ~mr;
    endcase
  end

  assign test_out = ser_mode & mux_out;
endmodule

module cfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pload_n,
  input logic           ser_load,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_n,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_code,
  input logic           test_out
);
  a_r1_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_n |=> (m_val == $past(par_m)) && (n_code == $past(par_n)));

  a_r2_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pload_n) && !ser_load && $past(rst_n)) |=> (m_val == $past(par_m)) && (n_code == $past(par_n)));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_n && $past(pload_n) && !ser_load && $past(rst_n)) |=> $stable(m_val) && $stable(n_code));

  a_r7_test_low_par: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_n |=> !test_out);
endmodule

bind cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .ser_load(ser_load),
  .par_m(par_m), .par_n(par_n), .m_val(m_val), .n_code(n_code), .test_out(test_out));

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  logic clk = 0, rst_n = 0, mr = 0, pload_n = 1;
  logic [8:0] par_m = 0;
  logic [2:0] par_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, fb_div_in = 0, out_clk_in = 0;
  logic [8:0] m_val;
  logic [2:0] n_code;
  logic test_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_loader u0 (.*);

  localparam logic [13:0] VEC [6] = '{
    {2'b00, 3'd1, 9'd250}, {2'b01, 3'd3, 9'd300}, {2'b10, 3'd5, 9'd499},
    {2'b11, 3'd2, 9'd1},   {2'b10, 3'd6, 9'd85},  {2'b11, 3'd4, 9'd511}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_data = b; ser_clk = 1; tick(); ser_clk = 0; tick();
  endtask

  task automatic send(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    ser_load = 1; tick(); ser_load = 0; tick();
  endtask

  initial begin
    #900us;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] sh;
    tick(); tick();
    check("R10 reset m", m_val, 250);
    check("R10 reset n", n_code, 0);
    check("R10 reset test", test_out, 0);
    rst_n = 1; tick();
    check("R10 m after release", m_val, 250);
    fb_div_in = 1; tick();
    check("R7 test low before serial load", test_out, 0);
    fb_div_in = 0;

    // R1 transparency
    pload_n = 0; par_m = 300; par_n = 5; tick();
    check("R1 m follows", m_val, 300);
    check("R1 n follows", n_code, 5);
    par_m = 123; tick();
    check("R1 m follows change", m_val, 123);
    // R2 capture on rise
    par_m = 400; par_n = 2; pload_n = 1; tick();
    check("R2 m captured", m_val, 400);
    par_m = 7; par_n = 1; tick(); tick();
    check("R2 m held", m_val, 400);
    check("R2 n held", n_code, 2);

    foreach (VEC[k]) begin
      logic [13:0] w;
      w = VEC[k];
      send(w);
      check("R3 m serial load", m_val, int'(w[8:0]));
      check("R3 n serial load", n_code, int'(w[11:9]));
      case (w[13:12])
        2'b00: begin
          fb_div_in = 1; out_clk_in = 1; #1;
          check("R6 sel00 low", test_out, 0);
          fb_div_in = 0; out_clk_in = 0;
        end
        2'b01: begin
          check("R6 sel01 oldest bit", test_out, int'(w[13]));
          shift_bit(1'b0);
          check("R6 sel01 after shift", test_out, int'(w[12]));
          check("R4 m unchanged after shift", m_val, int'(w[8:0]));
        end
        2'b10: begin
          fb_div_in = 1; #1;
          check("R6 sel10 high", test_out, 1);
          fb_div_in = 0; #1;
          check("R6 sel10 low", test_out, 0);
        end
        default: begin
          out_clk_in = 1; #1;
          check("R6 sel11 high", test_out, 1);
          out_clk_in = 0; #1;
          check("R6 sel11 low", test_out, 0);
        end
      endcase
    end

    // R8 divider reset
    out_clk_in = 1; mr = 1; tick();
    check("R8 test masked", test_out, 0);
    check("R8 m kept", m_val, 511);
    check("R8 n kept", n_code, 4);
    mr = 0; tick();
    check("R8 select kept", test_out, 1);

    // R7 parallel mode forces test low
    pload_n = 0; par_m = 42; par_n = 6; tick();
    check("R7 test low in parallel", test_out, 0);
    check("R1 m parallel again", m_val, 42);

    // R9 serial ignored in parallel mode
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    ser_load = 1; tick(); ser_load = 0; tick();
    check("R9 m not loaded", m_val, 42);
    pload_n = 1; tick();
    check("R2 m captured 42", m_val, 42);
    ser_load = 1; tick();
    check("R9 register not shifted m", m_val, 511);
    check("R9 register not shifted n", n_code, 4);

    // R5 transparent serial while ser_load held high
    sh = VEC[5];
    sh = {sh[12:0], 1'b0};
    ser_data = 0; ser_clk = 1; tick();
    check("R5 m follows shift", m_val, int'(sh[8:0]));
    check("R5 n follows shift", n_code, int'(sh[11:9]));
    ser_clk = 0; tick();
    sh = {sh[12:0], 1'b1};
    ser_data = 1; ser_clk = 1; tick();
    check("R5 m follows second shift", m_val, int'(sh[8:0]));
    ser_clk = 0; ser_load = 0; tick();
    shift_bit(1'b0);
    check("R4 latched after fall", m_val, int'(sh[8:0]));

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule